// File: doc/BRIEF.md
# ADC Control/Status and Conversion Sequencer

This block is the digital front end of a sixteen-input analog-to-digital converter. Software programs an 8-bit control/status register over a simple register bus. A start strobe then makes the block issue requests to an external conversion engine. Each request carries a channel number and is held until the engine returns a done pulse with a result. The block files each result in a data register of its own for that channel. It raises an end flag when the programmed job is complete and can turn that flag into an interrupt.

Two kinds of job exist. A single job converts one channel. A scan job walks upward through a four-channel group and repeats until a stop strobe arrives. Software clears the end flag in two steps: it reads the flag as one, then writes zero to it. A DMA acknowledge input also clears the flag. Power-on reset and standby entry both return the register to zero and halt any job.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After `rst` or a `stby` pulse, the control/status register (bus address 16) reads 0x00, `conv_req` is low and `irq` is low.
- R2: Register bits are: [7] end flag, [6] interrupt enable, [5:4] mode, [3:0] channel. A write stores bits 6:0, which read back unchanged. Writing 1 to bit 7 never sets the flag.
- R3: A write with bit 7 = 0 clears the end flag only if the register was read with the flag at 1 (a bus read with `bus_rd` high) after the previous register write. Otherwise the flag keeps its value.
- R4: A `dma_ack` pulse clears the end flag in the next cycle.
- R5: Mode 00, and the reserved modes 10 and 11, run one conversion of the channel in bits 3:0. On the clock edge that takes `conv_done`, the result goes into data register n (bus address n, 0 to 15, zero-extended), the flag is set and `conv_req` drops. `conv_ch` stays stable while a request waits.
- R6: Mode 01 scans group bits 3:2. It converts channels 4g, 4g+1, … up to 4g+bits 1:0 in ascending order and stores each result. The flag is set only on the edge that stores the last channel of the group, and the group then repeats.
- R7: A `stop` pulse during a scan ends the job after the conversion in flight. No further request follows.
- R8: `irq` is high exactly when both the end flag and the interrupt enable are 1.
- R9: When a hardware flag set and a software or DMA clear fall in the same cycle, the flag ends up set. The prior read is used up, so a later write of zero does not clear the flag until the register is read again.
- R10: A `start` pulse while a job is running is ignored. The running job keeps the channel and mode it captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| stby | input | 1 | Standby entry pulse; clears the register and halts the job |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | 0 to 15 data registers, 16 control/status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | RD_W (10) | Combinational read data |
| start | input | 1 | Starts a job from the current register settings |
| stop | input | 1 | Ends a scan after the current conversion |
| conv_req | output | 1 | Conversion request to the engine |
| conv_ch | output | 4 | Channel being requested |
| conv_done | input | 1 | Engine done pulse, valid while requested |
| conv_result | input | RES_W (10) | Result that comes with `conv_done` |
| dma_ack | input | 1 | DMA acknowledge; clears the end flag |
| irq | output | 1 | Conversion-end interrupt |

## Verification
The hardware set of the end flag can land in the same cycle as a clear. The clear may be a software zero-write after a valid read, or a DMA acknowledge. The bench arms the clear with a read while a flag from an earlier job is still up. It then watches the engine model, and in the very cycle that `conv_done` is seen it drives both the zero-write and `dma_ack`. The next sample must show the flag at 1. A following zero-write without a new read must leave the flag at 1, and a read followed by a write must then clear it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int NUM_CH   = 16;
    localparam int CH_W     = 4;
    localparam int ADDR_W   = 5;
    localparam int CSR_ADDR = 16;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_SCAN   = 2'b01,
        MODE_RSV_A  = 2'b10,
        MODE_RSV_B  = 2'b11
    } adc_mode_e;

    // field order matches the register bit layout, msb first
    typedef struct packed {
        logic            flag;
        logic            ie;
        adc_mode_e       mode;
        logic [CH_W-1:0] ch;
    } adc_csr_t;

    typedef struct packed {
        logic            scan;
        logic [CH_W-1:0] first;
        logic [CH_W-1:0] last;
    } adc_plan_t;

    typedef enum logic {SEQ_IDLE, SEQ_BUSY} seq_state_e;

    function automatic adc_plan_t plan_from_csr(input adc_csr_t c);
        adc_plan_t p;
        p.scan = (c.mode == MODE_SCAN);
        p.last = c.ch;
        p.first = p.scan ? {c.ch[CH_W-1:2], 2'b00} : c.ch;
        return p;
    endfunction

endpackage

// File: rtl/adc_csr.sv
module adc_csr
    import adc_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     stby,
    input  logic     rd_csr,
    input  logic     wr_csr,
    input  logic [7:0] wdata,
    input  logic     set_evt,
    input  logic     dma_ack,
    output adc_csr_t csr_q,
    output logic     armed
);

    logic clr_req;
    logic flag_nxt;
    logic armed_nxt;

    always_comb begin
        clr_req  = (wr_csr && !wdata[7] && armed) || dma_ack;
        flag_nxt = csr_q.flag;
        if (set_evt)      flag_nxt = 1'b1;
        else if (clr_req) flag_nxt = 1'b0;

        armed_nxt = armed;
        if (wr_csr)                 armed_nxt = 1'b0;
        if (rd_csr && csr_q.flag)   armed_nxt = 1'b1;
        if (!flag_nxt)              armed_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || stby) begin
            csr_q <= '0;
            armed <= 1'b0;
        end else begin
            csr_q.flag <= flag_nxt;
            armed      <= armed_nxt;
            if (wr_csr) begin
                csr_q.ie   <= wdata[6];
                csr_q.mode <= adc_mode_e'(wdata[5:4]);
                csr_q.ch   <= wdata[3:0];
            end
        end
    end

endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
    import adc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            stby,
    input  logic            start,
    input  logic            stop,
    input  adc_csr_t        csr_q,
    input  logic            conv_done,
    output logic            conv_req,
    output logic [CH_W-1:0] conv_ch,
    output logic            wr_en,
    output logic [CH_W-1:0] wr_ch,
    output logic            set_evt,
    output logic            one_shot
);

    seq_state_e      state;
    adc_plan_t       plan;
    logic [CH_W-1:0] cur;
    logic            stop_pend;
    logic            busy;
    logic            at_last;

    assign busy     = (state == SEQ_BUSY);
    assign at_last  = (cur == plan.last);
    assign conv_req = busy;
    assign conv_ch  = cur;
    assign wr_en    = busy && conv_done;
    assign wr_ch    = cur;
    assign set_evt  = wr_en && at_last;
    assign one_shot = busy && !plan.scan;

    always_ff @(posedge clk) begin
        if (rst || stby) begin
            state     <= SEQ_IDLE;
            plan      <= '0;
            cur       <= '0;
            stop_pend <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        plan      <= plan_from_csr(csr_q);
                        cur       <= plan_from_csr(csr_q).first;
                        stop_pend <= 1'b0;
                        state     <= SEQ_BUSY;
                    end
                end
                SEQ_BUSY: begin
                    if (stop) stop_pend <= 1'b1;
                    if (conv_done) begin
                        if (stop || stop_pend || !plan.scan) begin
                            state <= SEQ_IDLE;
                        end else if (at_last) begin
                            cur <= plan.first;
                        end else begin
                            cur <= cur + 1'b1;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [RES_W-1:0] wr_data,
    input  logic [CH_W-1:0]  rd_ch,
    output logic [RES_W-1:0] rd_data
);

    logic [RES_W-1:0] regs [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en && (wr_ch == CH_W'(g)))
                regs[g] <= wr_data;
        end
    end

    assign rd_data = regs[rd_ch];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10,
    localparam int RD_W = (RES_W > 8) ? RES_W : 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stby,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [RD_W-1:0]   bus_rdata,
    input  logic              start,
    input  logic              stop,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_ch,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    input  logic              dma_ack,
    output logic              irq
);

    adc_csr_t         csr_q;
    logic             armed;
    logic             rd_csr, wr_csr;
    logic             wr_en, set_evt, one_shot;
    logic [CH_W-1:0]  wr_ch;
    logic [RES_W-1:0] bank_rd;

    assign rd_csr = bus_rd && (bus_addr == ADDR_W'(CSR_ADDR));
    assign wr_csr = bus_wr && (bus_addr == ADDR_W'(CSR_ADDR));

    adc_csr u_csr (
        .clk(clk), .rst(rst), .stby(stby),
        .rd_csr(rd_csr), .wr_csr(wr_csr), .wdata(bus_wdata),
        .set_evt(set_evt), .dma_ack(dma_ack),
        .csr_q(csr_q), .armed(armed)
    );

    adc_sequencer u_seq (
        .clk(clk), .rst(rst), .stby(stby),
        .start(start), .stop(stop), .csr_q(csr_q),
        .conv_done(conv_done), .conv_req(conv_req), .conv_ch(conv_ch),
        .wr_en(wr_en), .wr_ch(wr_ch), .set_evt(set_evt), .one_shot(one_shot)
    );

    adc_result_bank #(.RES_W(RES_W)) u_bank (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(conv_result),
        .rd_ch(bus_addr[CH_W-1:0]), .rd_data(bank_rd)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CSR_ADDR))
            bus_rdata[7:0] = csr_q;
        else if (!bus_addr[ADDR_W-1])
            bus_rdata[RES_W-1:0] = bank_rd;
    end

    assign irq = csr_q.flag && csr_q.ie;

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
    input logic       clk,
    input logic       rst,
    input logic       stby,
    input logic       conv_req,
    input logic [3:0] conv_ch,
    input logic       conv_done,
    input logic       dma_ack,
    input logic       flag,
    input logic       armed,
    input logic       set_evt,
    input logic       one_shot
);

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) || $past(stby)) |-> !conv_req);

    a_r3_clear_needs_read: assert property (@(posedge clk) disable iff (rst)
        (flag && !armed && !dma_ack && !stby) |=> flag);

    a_r4_dma_clears: assert property (@(posedge clk) disable iff (rst)
        (dma_ack && !set_evt && !stby) |=> !flag);

    a_r5_single_ends: assert property (@(posedge clk) disable iff (rst)
        (conv_req && conv_done && one_shot && !stby) |=> (!conv_req && flag));

    a_r5_ch_stable: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !conv_done && !stby) |=> $stable(conv_ch));

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_evt && !stby) |=> flag);

endmodule

bind adc_seq_ctrl adc_seq_checker u_chk (
    .clk(clk), .rst(rst), .stby(stby),
    .conv_req(conv_req), .conv_ch(conv_ch), .conv_done(conv_done),
    .dma_ack(dma_ack), .flag(csr_q.flag), .armed(armed),
    .set_evt(set_evt), .one_shot(one_shot)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stby = 1'b0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [4:0] bus_addr = 5'd16;
    logic [7:0] bus_wdata = 8'h00;
    logic [9:0] bus_rdata;
    logic       start = 1'b0, stop = 1'b0;
    logic       conv_req;
    logic [3:0] conv_ch;
    logic       conv_done = 1'b0;
    logic [9:0] conv_result = '0;
    logic       dma_ack = 1'b0;
    logic       irq;

    int nchk = 0, nfail = 0, cycles = 0;
    bit finished = 0;
    int lat_cfg = 3, cnt = 0, log_n = 0;
    logic [3:0] log_ch [0:1023];
    logic [9:0] exp_res [0:15];

    always #10 clk = ~clk;

    adc_seq_ctrl dut (
        .clk(clk), .rst(rst), .stby(stby), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .start(start), .stop(stop), .conv_req(conv_req), .conv_ch(conv_ch),
        .conv_done(conv_done), .conv_result(conv_result), .dma_ack(dma_ack),
        .irq(irq)
    );

    // conversion engine model
    always @(negedge clk) begin
        logic [9:0] r;
        if (conv_done) begin
            conv_done = 1'b0;
            cnt = 0;
        end else if (conv_req) begin
            if (cnt >= lat_cfg) begin
                r = 10'($urandom);
                conv_done = 1'b1;
                conv_result = r;
                exp_res[conv_ch] = r;
                if (log_n < 1024) log_ch[log_n] = conv_ch;
                log_n = log_n + 1;
                cnt = 0;
            end else cnt = cnt + 1;
        end else cnt = 0;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !finished) begin
                finished = 1;
                nfail++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("  TB_RESULT checks=%0d failures=%0d", nchk + 1, nfail);
                $finish;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0; bus_addr = 5'd16;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [9:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0; bus_addr = 5'd16;
    endtask

    task automatic peek(input logic [4:0] a, output logic [9:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata; bus_addr = 5'd16;
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic wait_flag(output bit ok);
        ok = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk); #1;
            if (bus_rdata[7]) begin ok = 1; break; end
        end
    endtask

    function automatic logic [3:0] scan_ch(input int g, input int k, input int i);
        return 4'(g * 4 + (i % (k + 1)));
    endfunction

    initial begin
        logic [9:0] v;
        logic [7:0] w;
        bit ok;
        int base, g, k, ch, ie;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        peek(5'd16, v);
        chk("R1 csr after reset", v, 0);
        chk("R1 req after reset", conv_req, 0);
        chk("R1 irq after reset", irq, 0);

        // R2: bits 6:0 read back, bit 7 cannot be set
        bus_write(5'd16, 8'hFF);
        peek(5'd16, v);
        chk("R2 write ff", v, 10'h07F);
        for (int i = 0; i < 6; i++) begin
            w = 8'($urandom);
            bus_write(5'd16, w);
            peek(5'd16, v);
            chk("R2 random readback", v, {3'b0, w[6:0]});
        end

        // R5 / R8 / R3: single jobs, several modes and channels
        for (int i = 0; i < 6; i++) begin
            ch = $urandom_range(0, 15);
            ie = $urandom_range(0, 1);
            lat_cfg = $urandom_range(3, 5);
            w = {1'b0, 1'(ie), (i % 3 == 0) ? 2'b00 : ((i % 3 == 1) ? 2'b10 : 2'b11), 4'(ch)};
            bus_write(5'd16, w);
            base = log_n;
            pulse(start);
            wait_flag(ok);
            chk("R5 single flag set", ok, 1);
            chk("R5 req dropped", conv_req, 0);
            chk("R5 one conversion", log_n - base, 1);
            chk("R5 channel", log_ch[base], ch);
            chk("R8 irq follows enable", irq, ie);
            peek(5'(ch), v);
            chk("R5 data register", v, exp_res[ch]);
            // R3: zero-write without read does nothing
            bus_write(5'd16, w);
            peek(5'd16, v);
            chk("R3 no clear without read", v[7], 1);
            bus_read(5'd16, v);
            bus_write(5'd16, w);
            peek(5'd16, v);
            chk("R3 clear after read", v[7], 0);
            chk("R8 irq low after clear", irq, 0);
        end

        // R4: dma acknowledge clears the flag
        bus_write(5'd16, 8'h45);
        pulse(start);
        wait_flag(ok);
        pulse(dma_ack);
        peek(5'd16, v);
        chk("R4 dma clear", v[7], 0);

        // R9: set and clears in the same cycle
        bus_write(5'd16, 8'h07);
        pulse(start);
        wait_flag(ok);
        bus_read(5'd16, v);
        pulse(start);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk); #1;
            if (conv_done) break;
        end
        bus_addr = 5'd16; bus_wdata = 8'h07; bus_wr = 1'b1; dma_ack = 1'b1;
        @(negedge clk); bus_wr = 1'b0; dma_ack = 1'b0; #1;
        chk("R9 set wins", bus_rdata[7], 1);
        bus_write(5'd16, 8'h07);
        peek(5'd16, v);
        chk("R9 read consumed", v[7], 1);
        bus_read(5'd16, v);
        bus_write(5'd16, 8'h07);
        peek(5'd16, v);
        chk("R3 clear after re-read", v[7], 0);

        // R6 / R10 / R7: scans
        for (int t = 0; t < 4; t++) begin
            g = (t == 0) ? 3 : $urandom_range(0, 3);
            k = (t == 0) ? 3 : ((t == 1) ? 0 : $urandom_range(0, 3));
            lat_cfg = $urandom_range(3, 5);
            w = {2'b00, 2'b01, 2'(g), 2'(k)};
            bus_write(5'd16, w);
            base = log_n;
            pulse(start);
            // R10: restart with other settings is ignored
            bus_write(5'd16, {2'b00, 2'b00, 2'(g + 1), 2'(k + 1)});
            pulse(start);
            wait_flag(ok);
            chk("R6 scan flag", ok, 1);
            chk("R6 flag only at group end", log_n - base, k + 1);
            for (int i = 0; i <= k; i++)
                chk("R10 R6 order first pass", log_ch[base + i], scan_ch(g, k, i));
            bus_read(5'd16, v);
            bus_write(5'd16, v[7:0] & 8'h7F);
            wait_flag(ok);
            chk("R6 repeat count", log_n - base, 2 * (k + 1));
            for (int i = 0; i < 2 * (k + 1); i++)
                chk("R6 order second pass", log_ch[base + i], scan_ch(g, k, i));
            pulse(stop);
            for (int i = 0; i < 50 && conv_req; i++) @(negedge clk);
            chk("R7 stopped", conv_req, 0);
            base = log_n;
            repeat (12) @(negedge clk);
            chk("R7 no more requests", log_n - base, 0);
            for (int i = 0; i <= k; i++) begin
                peek(5'(g * 4 + i), v);
                chk("R6 group results", v, exp_res[g * 4 + i]);
            end
            bus_read(5'd16, v);
            bus_write(5'd16, 8'h00);
        end

        // R1: standby entry during a scan
        bus_write(5'd16, 8'h5E);
        pulse(start);
        repeat (4) @(negedge clk);
        pulse(stby);
        peek(5'd16, v);
        chk("R1 csr after standby", v, 0);
        chk("R1 req after standby", conv_req, 0);
        chk("R1 irq after standby", irq, 0);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule